// File: doc/BRIEF.md
# Endian-Selectable FIFO Byte Port

This block joins a pair of word-wide FIFOs, four 32-bit entries each, to a narrow local data port of 8 or 16 bits. A local read takes the next byte or halfword of the word at the head of the inbound FIFO. A local write places a byte or halfword into a staging word for the outbound FIFO. A sub-word pointer for each direction picks the lane. Whether bytes run from the least or the most significant end of the word is set by a byte-order input. The port width is set by a width input. Both inputs are captured only while reset is held.

The wide side pushes inbound words and pops outbound words. A simple DMA engine on the local side can move data by itself, using two active-low request outputs: one says the inbound FIFO has data, the other says the outbound FIFO has room. A channel clear input for each direction restarts that direction's sub-word pointer. The word already in the FIFO is left alone. A sticky flag records local writes that were dropped because the outbound FIFO was full.

Top module: `subword_fifo_port`

## Requirements
- R1: Each direction buffers exactly four 32-bit words. The full status of that direction rises when the fourth word is stored.
- R2: In 8-bit mode (wide_cfg_i=0) with byte order 0 (swap_cfg_i=0), four reads return lanes [7:0], [15:8], [23:16], [31:24] in that sequence. For the word 00C0FFEEh this is EE, FF, C0, 00, and bits [15:8] of lrd_data_o read zero.
- R3: In 8-bit mode with byte order 1, four reads return lanes [31:24] first and [7:0] last. For 00C0FFEEh this is 00, C0, FF, EE.
- R4: In 16-bit mode (wide_cfg_i=1), two reads move one word. Byte order 0 returns [15:0] then [31:16] (FFEE, 00C0). Byte order 1 returns [31:16] then [15:0] (00C0, FFEE).
- R5: Local writes fill the outbound word in the same lane sequence that R2 to R4 give for reads, for both widths and both byte orders.
- R6: The inbound word leaves the FIFO only on the last sub-word read of that word. The outbound word enters the FIFO only on the last sub-word write.
- R7: A pulse on in_clr_i or out_clr_i returns that direction's sub-word pointer to the first lane. A partly assembled outbound word is discarded. Words already queued are kept.
- R8: rd_req_no is low exactly while the inbound FIFO holds at least one word. wr_req_no is low exactly while the outbound FIFO has a free entry. in_empty_o and out_full_o report the same two conditions at active-high level.
- R9: A read while the inbound FIFO is empty returns zero and does not advance the pointer.
- R10: Any local write while the outbound FIFO is full is dropped, does not advance the pointer, and sets overflow_o. overflow_o then stays set until reset.
- R11: wide_cfg_i and swap_cfg_i take effect only as sampled on clock edges while rst_ni is low. Later changes have no effect.
- R12: After reset both FIFOs are empty: rd_req_no=1, wr_req_no=0, in_empty_o=1, out_empty_o=1, in_full_o=0, out_full_o=0, overflow_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; configuration is captured while low |
| wide_cfg_i | input | 1 | 1 = 16-bit local port, 0 = 8-bit |
| swap_cfg_i | input | 1 | Byte order: 0 = low lane first, 1 = high lane first |
| in_push_i | input | 1 | Wide side stores in_data_i into the inbound FIFO |
| in_data_i | input | 32 | Inbound word |
| in_full_o | output | 1 | Inbound FIFO full |
| out_pop_i | input | 1 | Wide side removes the outbound head word |
| out_data_o | output | 32 | Outbound head word |
| out_empty_o | output | 1 | Outbound FIFO empty |
| lrd_i | input | 1 | Local read strobe, one sub-word per cycle |
| lrd_data_o | output | 16 | Current inbound sub-word, zero-extended in 8-bit mode |
| lwr_i | input | 1 | Local write strobe, one sub-word per cycle |
| lwr_data_i | input | 16 | Local write data, low byte used in 8-bit mode |
| in_clr_i | input | 1 | Restart the inbound sub-word pointer |
| out_clr_i | input | 1 | Restart the outbound sub-word pointer and drop the partial word |
| in_empty_o | output | 1 | Inbound FIFO empty |
| out_full_o | output | 1 | Outbound FIFO full |
| rd_req_no | output | 1 | Active-low read request to a local DMA engine |
| wr_req_no | output | 1 | Active-low write request to a local DMA engine |
| overflow_o | output | 1 | Sticky flag for dropped local writes |

## Verification
The hardest case to reach is a write that is dropped on a full outbound FIFO in the middle of a word. A wrong design could advance the pointer there, and that would only show up one word later. The stimulus fills all four outbound entries and then issues extra writes. Next it pops one word and writes a whole new word. The new word must arrive intact behind the three survivors. A second hidden state is a pointer left in mid-word by a channel clear. This is exposed by reading a word partway, clearing, and then checking that the full four-lane sequence restarts from the first lane.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int unsigned WORD_W_DEF = 32;
  localparam int unsigned PORT_W_DEF = 16;
  localparam int unsigned DEPTH_DEF  = 4;

  // bit offset of sub-word idx inside the word
  function automatic int unsigned lane_shift(int unsigned idx, logic wide, logic swap,
                                             int unsigned nbytes);
    int unsigned steps;
    int unsigned pos;
    steps = wide ? nbytes / 2 : nbytes;
    pos   = swap ? steps - 1 - idx : idx;
    return wide ? pos * 16 : pos * 8;
  endfunction
endpackage

// File: rtl/sfp_word_fifo.sv
module sfp_word_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == FULL_CNT);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem[rp];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp] <= data_i;
  end

  assert_cnt_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= FULL_CNT);
  assert_no_underflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/sfp_read_splitter.sv
module sfp_read_splitter
  import sfp_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned PORT_W = PORT_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic              swap_i,
  input  logic              clr_i,
  input  logic              rd_i,
  input  logic [WORD_W-1:0] head_i,
  input  logic              empty_i,
  output logic [PORT_W-1:0] rdata_o,
  output logic              pop_o
);
  localparam int unsigned NBYTES = WORD_W / 8;
  localparam int unsigned PW     = $clog2(NBYTES);
  localparam logic [PW-1:0] LAST8  = PW'(NBYTES - 1);
  localparam logic [PW-1:0] LAST16 = PW'(NBYTES / 2 - 1);

  logic [PW-1:0]     ptr;
  logic              last;
  logic              adv;
  logic [WORD_W-1:0] sub;

  assign last = (ptr == (wide_i ? LAST16 : LAST8));
  assign adv  = rd_i && !empty_i && !clr_i;
  assign pop_o = adv && last;

  always_comb begin
    sub = head_i >> lane_shift(32'(ptr), wide_i, swap_i, NBYTES);
    if (empty_i)      rdata_o = '0;
    else if (wide_i)  rdata_o = sub[PORT_W-1:0];
    else              rdata_o = {{(PORT_W-8){1'b0}}, sub[7:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr <= '0;
    else if (clr_i)    ptr <= '0;
    else if (adv)      ptr <= last ? '0 : ptr + 1'b1;
  end

  assert_pop_wraps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> ptr == '0);
  assert_clr_ptr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ptr == '0);
  assert_empty_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && empty_i && !clr_i) |=> $stable(ptr));
endmodule

// File: rtl/sfp_write_packer.sv
module sfp_write_packer
  import sfp_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned PORT_W = PORT_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic              swap_i,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [PORT_W-1:0] wdata_i,
  input  logic              full_i,
  output logic              push_o,
  output logic [WORD_W-1:0] word_o,
  output logic              ovf_o
);
  localparam int unsigned NBYTES = WORD_W / 8;
  localparam int unsigned PW     = $clog2(NBYTES);
  localparam logic [PW-1:0] LAST8  = PW'(NBYTES - 1);
  localparam logic [PW-1:0] LAST16 = PW'(NBYTES / 2 - 1);

  logic [PW-1:0]     ptr;
  logic [WORD_W-1:0] acc, mask, din;
  logic              last, adv;

  assign last   = (ptr == (wide_i ? LAST16 : LAST8));
  assign adv    = wr_i && !full_i && !clr_i;
  assign push_o = adv && last;

  always_comb begin
    mask   = (wide_i ? WORD_W'(16'hFFFF) : WORD_W'(8'hFF))
             << lane_shift(32'(ptr), wide_i, swap_i, NBYTES);
    din    = WORD_W'(wdata_i) << lane_shift(32'(ptr), wide_i, swap_i, NBYTES);
    word_o = (acc & ~mask) | (din & mask);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr   <= '0;
      acc   <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (wr_i && full_i && !clr_i) ovf_o <= 1'b1;
      if (clr_i) begin
        ptr <= '0;
        acc <= '0;
      end else if (adv) begin
        ptr <= last ? '0 : ptr + 1'b1;
        acc <= last ? '0 : word_o;
      end
    end
  end

  assert_push_wraps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> ptr == '0);
  assert_clr_ptr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ptr == '0);
  assert_full_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_i && !clr_i) |=> ($stable(ptr) && ovf_o));
  assert_ovf_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
endmodule

// File: rtl/subword_fifo_port.sv
module subword_fifo_port
  import sfp_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned PORT_W = PORT_W_DEF,
  parameter int unsigned DEPTH  = DEPTH_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_cfg_i,
  input  logic              swap_cfg_i,
  input  logic              in_push_i,
  input  logic [WORD_W-1:0] in_data_i,
  output logic              in_full_o,
  input  logic              out_pop_i,
  output logic [WORD_W-1:0] out_data_o,
  output logic              out_empty_o,
  input  logic              lrd_i,
  output logic [PORT_W-1:0] lrd_data_o,
  input  logic              lwr_i,
  input  logic [PORT_W-1:0] lwr_data_i,
  input  logic              in_clr_i,
  input  logic              out_clr_i,
  output logic              in_empty_o,
  output logic              out_full_o,
  output logic              rd_req_no,
  output logic              wr_req_no,
  output logic              overflow_o
);
  logic              wide_q, swap_q;
  logic [WORD_W-1:0] in_head, pk_word;
  logic              in_pop, pk_push;

  // configuration captured only while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      wide_q <= wide_cfg_i;
      swap_q <= swap_cfg_i;
    end
  end

  sfp_word_fifo #(.W(WORD_W), .DEPTH(DEPTH)) i_in_fifo (
    .clk_i, .rst_ni,
    .push_i(in_push_i), .data_i(in_data_i),
    .pop_i(in_pop), .data_o(in_head),
    .empty_o(in_empty_o), .full_o(in_full_o)
  );

  sfp_read_splitter #(.WORD_W(WORD_W), .PORT_W(PORT_W)) i_split (
    .clk_i, .rst_ni,
    .wide_i(wide_q), .swap_i(swap_q), .clr_i(in_clr_i),
    .rd_i(lrd_i), .head_i(in_head), .empty_i(in_empty_o),
    .rdata_o(lrd_data_o), .pop_o(in_pop)
  );

  sfp_write_packer #(.WORD_W(WORD_W), .PORT_W(PORT_W)) i_pack (
    .clk_i, .rst_ni,
    .wide_i(wide_q), .swap_i(swap_q), .clr_i(out_clr_i),
    .wr_i(lwr_i), .wdata_i(lwr_data_i), .full_i(out_full_o),
    .push_o(pk_push), .word_o(pk_word), .ovf_o(overflow_o)
  );

  sfp_word_fifo #(.W(WORD_W), .DEPTH(DEPTH)) i_out_fifo (
    .clk_i, .rst_ni,
    .push_i(pk_push), .data_i(pk_word),
    .pop_i(out_pop_i), .data_o(out_data_o),
    .empty_o(out_empty_o), .full_o(out_full_o)
  );

  assign rd_req_no = in_empty_o;
  assign wr_req_no = out_full_o;

  assert_cfg_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ($stable(wide_q) && $stable(swap_q)));
  assert_req_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_push_i && !lrd_i && !in_clr_i) |=> $stable(rd_req_no));
endmodule

// File: tb/test_subword_fifo_port.sv
module test_subword_fifo_port;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wide_cfg = 0, swap_cfg = 0;
  logic        in_push = 0, out_pop = 0, lrd = 0, lwr = 0, in_clr = 0, out_clr = 0;
  logic [31:0] in_data = '0;
  logic [15:0] lwr_data = '0;
  logic        in_full, out_empty, in_empty, out_full, rd_req_n, wr_req_n, ovf;
  logic [31:0] out_data;
  logic [15:0] lrd_data;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  subword_fifo_port i_subword_fifo_port (
    .clk_i(clk), .rst_ni(rst_n), .wide_cfg_i(wide_cfg), .swap_cfg_i(swap_cfg),
    .in_push_i(in_push), .in_data_i(in_data), .in_full_o(in_full),
    .out_pop_i(out_pop), .out_data_o(out_data), .out_empty_o(out_empty),
    .lrd_i(lrd), .lrd_data_o(lrd_data), .lwr_i(lwr), .lwr_data_i(lwr_data),
    .in_clr_i(in_clr), .out_clr_i(out_clr), .in_empty_o(in_empty),
    .out_full_o(out_full), .rd_req_no(rd_req_n), .wr_req_no(wr_req_n),
    .overflow_o(ovf)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic w, logic s);
    @(negedge clk);
    rst_n = 0; wide_cfg = w; swap_cfg = s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    wide_cfg = ~w; swap_cfg = ~s;  // later changes must be ignored (R11)
  endtask

  task automatic push_in(logic [31:0] d);
    @(negedge clk); in_push = 1; in_data = d;
    @(negedge clk); in_push = 0;
  endtask

  task automatic rd_sub(output logic [15:0] v);
    @(negedge clk); lrd = 1; #1 v = lrd_data;
    @(negedge clk); lrd = 0;
  endtask

  task automatic wr_sub(logic [15:0] d);
    @(negedge clk); lwr = 1; lwr_data = d;
    @(negedge clk); lwr = 0;
  endtask

  task automatic pop_out(output logic [31:0] v);
    @(negedge clk); out_pop = 1; #1 v = out_data;
    @(negedge clk); out_pop = 0;
  endtask

  task automatic t_reset;
    do_reset(0, 0);
    #1;
    chk("R12 rd_req_no", rd_req_n, 1); chk("R12 wr_req_no", wr_req_n, 0);
    chk("R12 in_empty", in_empty, 1);  chk("R12 out_empty", out_empty, 1);
    chk("R12 in_full", in_full, 0);    chk("R12 out_full", out_full, 0);
    chk("R12 overflow", ovf, 0);
  endtask

  task automatic t_rd8_le;
    logic [15:0] v;
    logic [7:0] exp [4] = '{8'hEE, 8'hFF, 8'hC0, 8'h00};
    do_reset(0, 0);
    push_in(32'h00C0FFEE);
    #1 chk("R8 rd_req low with data", rd_req_n, 0);
    for (int i = 0; i < 4; i++) begin
      rd_sub(v);
      chk("R2 byte order le", v, {8'h00, exp[i]});
      #1 if (i < 3) chk("R6 no pop before last", in_empty, 0);
    end
    #1 chk("R6 pop on last", in_empty, 1);
    chk("R8 rd_req high when empty", rd_req_n, 1);
  endtask

  task automatic t_rd8_be;
    logic [15:0] v;
    logic [7:0] exp [4] = '{8'h00, 8'hC0, 8'hFF, 8'hEE};
    do_reset(0, 1);  // cfg inputs now flip to 16-bit/le; must not apply (R11)
    push_in(32'h00C0FFEE);
    for (int i = 0; i < 4; i++) begin
      rd_sub(v);
      chk("R3 R11 byte order be", v, {8'h00, exp[i]});
    end
  endtask

  task automatic t_rd16;
    logic [15:0] v;
    do_reset(1, 0);
    push_in(32'h00C0FFEE);
    rd_sub(v); chk("R4 16 le first", v, 16'hFFEE);
    rd_sub(v); chk("R4 16 le second", v, 16'h00C0);
    #1 chk("R4 16 pop after two", in_empty, 1);
    do_reset(1, 1);
    push_in(32'h00C0FFEE);
    rd_sub(v); chk("R4 16 be first", v, 16'h00C0);
    rd_sub(v); chk("R4 16 be second", v, 16'hFFEE);
  endtask

  task automatic t_wr;
    logic [31:0] w;
    do_reset(0, 0);
    wr_sub(16'h00EE); wr_sub(16'h00FF); wr_sub(16'h00C0);
    #1 chk("R6 no push before last", out_empty, 1);
    wr_sub(16'h0000);
    pop_out(w); chk("R5 write 8 le", w, 32'h00C0FFEE);
    do_reset(0, 1);
    wr_sub(16'h0000); wr_sub(16'h00C0); wr_sub(16'h00FF); wr_sub(16'h00EE);
    pop_out(w); chk("R5 write 8 be", w, 32'h00C0FFEE);
    do_reset(1, 1);
    wr_sub(16'h00C0); wr_sub(16'hFFEE);
    pop_out(w); chk("R5 write 16 be", w, 32'h00C0FFEE);
  endtask

  task automatic t_fill;
    logic [31:0] w;
    do_reset(1, 0);
    for (int i = 0; i < 3; i++) push_in(32'h1000 + i);
    #1 chk("R1 in not full at 3", in_full, 0);
    push_in(32'h1003);
    #1 chk("R1 in full at 4", in_full, 1);
    for (int i = 0; i < 4; i++) begin
      #1 chk("R8 wr_req low with room", wr_req_n, 0);
      wr_sub(16'(i)); wr_sub(16'hA000 + 16'(i));
    end
    #1 chk("R1 out full at 4", out_full, 1);
    chk("R8 wr_req high when full", wr_req_n, 1);
    chk("R10 no overflow yet", ovf, 0);
    wr_sub(16'hDEAD);
    #1 chk("R10 overflow set", ovf, 1);
    pop_out(w); chk("R10 first word intact", w, 32'hA0000000);
    wr_sub(16'h5555); wr_sub(16'h6666);
    for (int i = 1; i < 4; i++) begin
      pop_out(w); chk("R10 survivors", w, {16'hA000 + 16'(i), 16'(i)});
    end
    pop_out(w); chk("R10 pointer unmoved by drop", w, 32'h66665555);
    #1 chk("R10 overflow sticky", ovf, 1);
  endtask

  task automatic t_empty_read;
    logic [15:0] v;
    do_reset(0, 0);
    rd_sub(v); chk("R9 empty read zero", v, 0);
    push_in(32'h44332211);
    rd_sub(v); chk("R9 pointer not advanced", v, 16'h0011);
  endtask

  task automatic t_clr;
    logic [15:0] v;
    logic [31:0] w;
    do_reset(0, 0);
    push_in(32'h44332211);
    rd_sub(v); rd_sub(v);
    @(negedge clk); in_clr = 1; @(negedge clk); in_clr = 0;
    #1 chk("R7 word kept after clear", in_empty, 0);
    rd_sub(v); chk("R7 restart at first lane", v, 16'h0011);
    rd_sub(v); rd_sub(v); rd_sub(v); chk("R7 last lane", v, 16'h0044);
    wr_sub(16'h0099); wr_sub(16'h0088);
    @(negedge clk); out_clr = 1; @(negedge clk); out_clr = 0;
    wr_sub(16'h0001); wr_sub(16'h0002); wr_sub(16'h0003); wr_sub(16'h0004);
    pop_out(w); chk("R7 outbound restarted", w, 32'h04030201);
    #1 chk("R7 only one word", out_empty, 1);
  endtask

  initial begin
    fork
      begin
        t_reset; t_rd8_le; t_rd8_be; t_rd16; t_wr; t_fill; t_empty_read; t_clr;
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule